// File: doc/BRIEF.md
# Programmable Clock Channel Divider

This block divides a fast input clock for one output channel. It is modelled as synchronous logic running at the input rate, and its output is a level that is sampled once per input cycle, in the manner of a clock enable. The lengths of the high phase and the low phase each come from their own 4-bit field, written as the cycle count minus one. Changes to either field take effect only at the next phase boundary, so the output never produces a shortened pulse.

A chip-level synchronisation request holds the counter at a chosen start level. After the request is released, the counter waits a programmable number of input cycles before the first phase starts. A channel can be told to ignore synchronisation. While synchronisation is ignored, the channel can also be forced to a static high level.

Further up the output path sit four stages:
- a bypass, which idles the counter and passes the input rate straight through;
- a direct-route select, which feeds the channel from one of two alternate sources chosen by a global 2-bit select;
- a power-down, which parks the output low;
- reset, which leaves the output low at the start of a default four-cycle low phase.

Top module: `clkdiv_channel`

## Requirements
- R1: While reset is asserted the output is low. After release the first low phase lasts RST_LOW_M1+1 cycles (4 by default), whatever the value of the low-count field.
- R2: With nothing overriding the output, each low phase lasts cfg_low_m1+1 input cycles. A field value of 0 gives a one-cycle phase.
- R3: With nothing overriding the output, each high phase lasts cfg_high_m1+1 input cycles. The output alternates between low and high phases.
- R4: A change to cfg_low_m1 or cfg_high_m1 during a phase leaves that phase at its old length. The new value applies to the next phase of that polarity.
- R5: While sync_req is 1 and cfg_sync_ignore is 0, the output holds cfg_start_high (1 = high, 0 = low) and the phase count restarts.
- R6: After sync_req falls with cfg_sync_ignore at 0, the output stays at the start level for cfg_phase_ofs cycles, then for a full first phase of that polarity.
- R7: When cfg_sync_ignore is 1, sync_req has no effect on the output. The divider keeps running.
- R8: With cfg_sync_ignore at 1, cfg_force_high at 1 drives the output high. With cfg_sync_ignore at 0, cfg_force_high has no effect.
- R9: cfg_bypass at 1 drives the output to 1 on every cycle and holds the counter idle. When bypass is cleared, a fresh low phase of cfg_low_m1+1 cycles begins.
- R10: cfg_pwrdn at 1 drives the output low above every other control. It also parks the counter as R9 does.
- R11: When cfg_direct is 1, the route select chooses the output source:
  - route_sel 2'b10 passes alt_src_a;
  - route_sel 2'b00 passes alt_src_b;
  - 2'b01 and 2'b11 keep the divider path.
  When cfg_direct is 0, the divider path is always used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_req | input | 1 | Chip-level synchronisation request, active high |
| cfg_low_m1 | input | CNT_W | Low phase length minus one |
| cfg_high_m1 | input | CNT_W | High phase length minus one |
| cfg_phase_ofs | input | CNT_W | Cycles to wait after sync release |
| cfg_start_high | input | 1 | Start level after sync: 1 high, 0 low |
| cfg_sync_ignore | input | 1 | 1: sync_req is not obeyed |
| cfg_force_high | input | 1 | Static high output, effective only with cfg_sync_ignore |
| cfg_bypass | input | 1 | Idle the counter and pass the input rate through |
| cfg_pwrdn | input | 1 | Channel power-down, output low |
| cfg_direct | input | 1 | Take the output from an alternate source |
| route_sel | input | 2 | Global alternate source select |
| alt_src_a | input | 1 | Alternate source chosen by 2'b10 |
| alt_src_b | input | 1 | Alternate source chosen by 2'b00 |
| div_out | output | 1 | Channel output level |

## Verification
A corrupted count or a stale phase length shows up as a phase that is one or more cycles too long or too short. The output then drifts from the expected waveform within a single period, at most 32 cycles with 4-bit fields. A wrong offset count, or a start level not captured during a hold, is visible on the first cycle after sync release or within the next 16 cycles. Selector faults appear in the same cycle, because the final selection is combinational on the registered phase.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  // Global route select encodings; the values are decoded by the output selector.
  typedef enum logic [1:0] {
    SRC_ALT_B   = 2'b00,
    SRC_DIVIDER = 2'b01,
    SRC_ALT_A   = 2'b10,
    SRC_RSVD    = 2'b11
  } route_sel_e;

  typedef enum logic [1:0] {
    OSRC_DIV,
    OSRC_ALT_A,
    OSRC_ALT_B
  } out_src_e;

  // Chooses which source feeds the channel.
  function automatic out_src_e pick_source(input logic direct, input route_sel_e sel);
    if (!direct)                 return OSRC_DIV;
    else if (sel == SRC_ALT_A)   return OSRC_ALT_A;
    else if (sel == SRC_ALT_B)   return OSRC_ALT_B;
    else                         return OSRC_DIV;
  endfunction

endpackage

// File: rtl/clkdiv_sync_ctrl.sv
`timescale 1ns/1ps
module clkdiv_sync_ctrl #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic             sync_req,
  input  logic             sync_ignore,
  input  logic [CNT_W-1:0] phase_ofs,
  output logic             hold,
  output logic             ofs_wait,
  output logic             run
);

  logic [CNT_W-1:0] ofs_cnt;

  assign hold     = !idle && sync_req && !sync_ignore;
  assign ofs_wait = !idle && !hold && (ofs_cnt != '0);
  assign run      = !idle && !hold && (ofs_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_cnt <= '0;
    end else if (idle) begin
      ofs_cnt <= '0;
    end else if (hold) begin
      ofs_cnt <= phase_ofs;
    end else if (ofs_wait) begin
      ofs_cnt <= ofs_cnt - 1'b1;
    end
  end

  AST_OFS_LOADED_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (ofs_cnt == $past(phase_ofs))); // R6

  AST_IDLE_CLEARS_OFS: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (ofs_cnt == '0)); // R9

endmodule

// File: rtl/clkdiv_phase_counter.sv
`timescale 1ns/1ps
module clkdiv_phase_counter #(
  parameter int CNT_W      = 4,
  parameter int RST_LOW_M1 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic             hold,
  input  logic             run,
  input  logic             start_high,
  input  logic [CNT_W-1:0] high_m1,
  input  logic [CNT_W-1:0] low_m1,
  output logic             phase_hi,
  output logic             phase_end
);

  localparam logic [CNT_W-1:0] RST_LEN = CNT_W'(RST_LOW_M1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cur_len;

  // Length (minus one) of the phase whose level is hi_next.
  function automatic logic [CNT_W-1:0] len_for(input logic hi_next,
                                               input logic [CNT_W-1:0] hi_m1,
                                               input logic [CNT_W-1:0] lo_m1);
    return hi_next ? hi_m1 : lo_m1;
  endfunction

  assign phase_end = run && (cnt == cur_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_hi <= 1'b0;
      cnt      <= '0;
      cur_len  <= RST_LEN;
    end else if (idle) begin
      phase_hi <= 1'b0;
      cnt      <= '0;
      cur_len  <= low_m1;
    end else if (hold) begin
      phase_hi <= start_high;
      cnt      <= '0;
      cur_len  <= len_for(start_high, high_m1, low_m1);
    end else if (phase_end) begin
      phase_hi <= !phase_hi;
      cnt      <= '0;
      cur_len  <= len_for(!phase_hi, high_m1, low_m1);
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cur_len); // R2

  AST_END_FLIPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    phase_end |=> (phase_hi != $past(phase_hi))); // R3

  AST_LEN_STABLE_MIDPHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_end && !hold && !idle) |=> $stable(cur_len)); // R4

  AST_HOLD_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (phase_hi == $past(start_high)) && (cnt == '0)); // R5

endmodule

// File: rtl/clkdiv_out_select.sv
`timescale 1ns/1ps
module clkdiv_out_select
  import clkdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrdn,
  input  logic       direct,
  input  logic [1:0] route_sel,
  input  logic       alt_a,
  input  logic       alt_b,
  input  logic       bypass,
  input  logic       sync_ignore,
  input  logic       force_high,
  input  logic       phase_hi,
  output logic       div_out
);

  out_src_e src;
  logic     div_path;

  assign src = pick_source(direct, route_sel_e'(route_sel));

  always_comb begin
    if (bypass)                         div_path = 1'b1;
    else if (sync_ignore && force_high) div_path = 1'b1;
    else                                div_path = phase_hi;
  end

  always_comb begin
    if (pwrdn) begin
      div_out = 1'b0;
    end else begin
      unique case (src)
        OSRC_ALT_A: div_out = alt_a;
        OSRC_ALT_B: div_out = alt_b;
        default:    div_out = div_path;
      endcase
    end
  end

  AST_PWRDN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn |-> !div_out); // R10

  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwrdn && !direct && !bypass && sync_ignore && force_high) |-> div_out); // R8

endmodule

// File: rtl/clkdiv_channel.sv
`timescale 1ns/1ps
module clkdiv_channel #(
  parameter int CNT_W      = 4,
  parameter int RST_LOW_M1 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_req,
  input  logic [CNT_W-1:0] cfg_low_m1,
  input  logic [CNT_W-1:0] cfg_high_m1,
  input  logic [CNT_W-1:0] cfg_phase_ofs,
  input  logic             cfg_start_high,
  input  logic             cfg_sync_ignore,
  input  logic             cfg_force_high,
  input  logic             cfg_bypass,
  input  logic             cfg_pwrdn,
  input  logic             cfg_direct,
  input  logic [1:0]       route_sel,
  input  logic             alt_src_a,
  input  logic             alt_src_b,
  output logic             div_out
);

  // Internal events, named for the assertions.
  logic ctr_idle;
  logic sync_hold;
  logic ofs_wait;
  logic ctr_run;
  logic phase_hi;
  logic phase_end;

  assign ctr_idle = cfg_pwrdn || cfg_bypass;

  clkdiv_sync_ctrl #(.CNT_W(CNT_W)) i_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle       (ctr_idle),
    .sync_req   (sync_req),
    .sync_ignore(cfg_sync_ignore),
    .phase_ofs  (cfg_phase_ofs),
    .hold       (sync_hold),
    .ofs_wait   (ofs_wait),
    .run        (ctr_run)
  );

  clkdiv_phase_counter #(.CNT_W(CNT_W), .RST_LOW_M1(RST_LOW_M1)) i_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle      (ctr_idle),
    .hold      (sync_hold),
    .run       (ctr_run),
    .start_high(cfg_start_high),
    .high_m1   (cfg_high_m1),
    .low_m1    (cfg_low_m1),
    .phase_hi  (phase_hi),
    .phase_end (phase_end)
  );

  clkdiv_out_select i_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwrdn      (cfg_pwrdn),
    .direct     (cfg_direct),
    .route_sel  (route_sel),
    .alt_a      (alt_src_a),
    .alt_b      (alt_src_b),
    .bypass     (cfg_bypass),
    .sync_ignore(cfg_sync_ignore),
    .force_high (cfg_force_high),
    .phase_hi   (phase_hi),
    .div_out    (div_out)
  );

  AST_WAIT_FREEZES_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_wait |=> $stable(phase_hi)); // R6

  AST_IGNORED_SYNC_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sync_ignore && !ctr_idle) |-> !sync_hold); // R7

  AST_IDLE_PARKS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_idle |=> !phase_hi); // R9

  AST_NO_END_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_hold || ofs_wait || ctr_idle) |-> !phase_end); // R5

endmodule

// File: tb/test_clkdiv_channel.sv
`timescale 1ns/1ps
module test_clkdiv_channel;

  localparam int W      = 4;
  localparam int RST_LO = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sync_req = 1'b0;
  logic [W-1:0] cfg_low_m1 = 4'd3;
  logic [W-1:0] cfg_high_m1 = 4'd1;
  logic [W-1:0] cfg_phase_ofs = 4'd0;
  logic         cfg_start_high = 1'b0;
  logic         cfg_sync_ignore = 1'b0;
  logic         cfg_force_high = 1'b0;
  logic         cfg_bypass = 1'b0;
  logic         cfg_pwrdn = 1'b0;
  logic         cfg_direct = 1'b0;
  logic [1:0]   route_sel = 2'b01;
  logic         alt_src_a = 1'b0;
  logic         alt_src_b = 1'b0;
  logic         div_out;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    chk_en   = 1'b0;
  bit    done     = 1'b0;
  string cur_tag  = "R1";

  // Reference state: level and cycles still to go in the current phase.
  bit m_lvl  = 1'b0;
  int m_left = RST_LO + 1;
  int m_wait = 0;

  always #2.5 clk = ~clk;

  clkdiv_channel #(.CNT_W(W), .RST_LOW_M1(RST_LO)) i_clkdiv_channel (
    .clk(clk), .rst_n(rst_n), .sync_req(sync_req),
    .cfg_low_m1(cfg_low_m1), .cfg_high_m1(cfg_high_m1), .cfg_phase_ofs(cfg_phase_ofs),
    .cfg_start_high(cfg_start_high), .cfg_sync_ignore(cfg_sync_ignore),
    .cfg_force_high(cfg_force_high), .cfg_bypass(cfg_bypass), .cfg_pwrdn(cfg_pwrdn),
    .cfg_direct(cfg_direct), .route_sel(route_sel), .alt_src_a(alt_src_a),
    .alt_src_b(alt_src_b), .div_out(div_out)
  );

  function automatic int span(bit hi);
    return hi ? int'(cfg_high_m1) + 1 : int'(cfg_low_m1) + 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lvl = 1'b0; m_left = RST_LO + 1; m_wait = 0;
    end else if (cfg_pwrdn || cfg_bypass) begin
      m_lvl = 1'b0; m_left = span(1'b0); m_wait = 0;
    end else if (sync_req && !cfg_sync_ignore) begin
      m_lvl = cfg_start_high; m_left = span(cfg_start_high); m_wait = int'(cfg_phase_ofs);
    end else if (m_wait > 0) begin
      m_wait = m_wait - 1;
    end else begin
      m_left = m_left - 1;
      if (m_left == 0) begin
        m_lvl  = !m_lvl;
        m_left = span(m_lvl);
      end
    end
  end

  function automatic bit expect_out();
    if (cfg_pwrdn)                              return 1'b0;
    if (cfg_direct && route_sel == 2'b10)       return alt_src_a;
    if (cfg_direct && route_sel == 2'b00)       return alt_src_b;
    if (cfg_bypass)                             return 1'b1;
    if (cfg_sync_ignore && cfg_force_high)      return 1'b1;
    return m_lvl;
  endfunction

  function automatic string rnd_tag();
    if (cfg_pwrdn) return "R10";
    if (cfg_direct && (route_sel == 2'b10 || route_sel == 2'b00)) return "R11";
    if (cfg_bypass) return "R9";
    if (cfg_sync_ignore && cfg_force_high) return "R8";
    if (cfg_sync_ignore && sync_req) return "R7";
    if (sync_req || m_wait > 0) return "R5";
    return m_lvl ? "R3" : "R2";
  endfunction

  always @(negedge clk) begin
    #1;
    if (chk_en && rst_n) begin
      bit    e;
      string t;
      e = expect_out();
      t = (cur_tag == "RND") ? rnd_tag() : cur_tag;
      n_checks++;
      if (div_out !== e) begin
        n_fails++;
        $display("FAIL %s at %0t: div_out actual=%0b expected=%0b", t, $time, div_out, e);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    #900us;
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    // R1: reset state
    cyc(3);
    #1;
    n_checks++;
    if (div_out !== 1'b0) begin
      n_fails++;
      $display("FAIL R1 reset: div_out actual=%0b expected=0", div_out);
    end
    @(negedge clk);
    cfg_low_m1 = 4'd9;           // R1: first low phase keeps reset length
    rst_n = 1'b1; chk_en = 1'b1; cur_tag = "R1";
    cyc(12);
    cfg_low_m1 = 4'd3;
    cyc(10);
    // R2 / R3: several phase lengths
    cur_tag = "R2";
    cfg_low_m1 = 4'd0; cfg_high_m1 = 4'd0; cyc(12);
    cfg_low_m1 = 4'd7; cfg_high_m1 = 4'd2; cyc(30);
    cur_tag = "R3";
    cfg_low_m1 = 4'd15; cfg_high_m1 = 4'd15; cyc(70);
    cfg_low_m1 = 4'd1; cfg_high_m1 = 4'd12; cyc(40);
    // R4: mid-phase change
    cur_tag = "R4";
    cfg_low_m1 = 4'd5; cfg_high_m1 = 4'd5; cyc(15);
    cfg_low_m1 = 4'd1; cfg_high_m1 = 4'd9; cyc(3);
    cfg_low_m1 = 4'd11; cyc(40);
    // R5: hold at start level, both polarities
    cur_tag = "R5";
    sync_req = 1'b1; cfg_start_high = 1'b0; cyc(5);
    cfg_start_high = 1'b1; cyc(5);
    // R6: offset wait after release
    cur_tag = "R6";
    cfg_phase_ofs = 4'd6; sync_req = 1'b0; cyc(40);
    sync_req = 1'b1; cfg_phase_ofs = 4'd15; cfg_start_high = 1'b0; cyc(2);
    sync_req = 1'b0; cyc(45);
    cfg_phase_ofs = 4'd0; sync_req = 1'b1; cyc(1); sync_req = 1'b0; cyc(20);
    // R7: sync ignored
    cur_tag = "R7";
    cfg_sync_ignore = 1'b1; sync_req = 1'b1; cyc(30);
    sync_req = 1'b0; cyc(5);
    // R8: force with and without ignore
    cur_tag = "R8";
    cfg_force_high = 1'b1; cyc(10);
    cfg_sync_ignore = 1'b0; cyc(25);
    cfg_force_high = 1'b0;
    // R9: bypass and restart
    cur_tag = "R9";
    cfg_bypass = 1'b1; cyc(10);
    cfg_bypass = 1'b0; cyc(30);
    // R10: power-down dominates
    cur_tag = "R10";
    cfg_pwrdn = 1'b1; cfg_bypass = 1'b1; cfg_sync_ignore = 1'b1; cfg_force_high = 1'b1;
    cfg_direct = 1'b1; route_sel = 2'b10; alt_src_a = 1'b1; cyc(10);
    cfg_pwrdn = 1'b0; cfg_bypass = 1'b0; cfg_sync_ignore = 1'b0; cfg_force_high = 1'b0;
    cfg_direct = 1'b0; cyc(20);
    // R11: direct routing
    cur_tag = "R11";
    cfg_direct = 1'b1;
    for (int s = 0; s < 4; s++) begin
      route_sel = 2'(s);
      repeat (20) begin
        alt_src_a = 1'($urandom); alt_src_b = 1'($urandom); cyc(1);
      end
    end
    cfg_direct = 1'b0; route_sel = 2'b10;
    repeat (20) begin
      alt_src_a = 1'($urandom); alt_src_b = 1'($urandom); cyc(1);
    end
    // Constrained random mix
    cur_tag = "RND";
    repeat (15000) begin
      alt_src_a = 1'($urandom); alt_src_b = 1'($urandom);
      if ($urandom % 30 == 0) begin
        case ($urandom % 12)
          0:  cfg_low_m1 = 4'($urandom);
          1:  cfg_high_m1 = 4'($urandom);
          2:  cfg_phase_ofs = 4'($urandom);
          3:  cfg_start_high = 1'($urandom);
          4:  cfg_sync_ignore = ($urandom % 3 == 0);
          5:  cfg_force_high = 1'($urandom);
          6:  cfg_bypass = ($urandom % 4 == 0);
          7:  cfg_pwrdn = ($urandom % 5 == 0);
          8:  cfg_direct = ($urandom % 3 == 0);
          9:  route_sel = 2'($urandom);
          default: sync_req = ($urandom % 3 == 0);
        endcase
      end
      cyc(1);
    end
    done = 1'b1;
    report();
    $finish;
  end

endmodule